// File: doc/BRIEF.md
# Microcoded I2C Bus Sequencer

This block produces the SCL and SDA waveforms of an I2C controller from a program of micro-instructions that the host writes into an on-chip store. No fixed I2C state machine is involved. Each entry gives the levels of both lines, a flag that samples SDA, a busy flag and the address of the entry that follows it. The host therefore builds start, stop, write-bit and read-bit patterns as linked chains of entries.

To run a transfer, the host first loads the store through a single write-word port. It then pulses a kick input and polls a running flag. Once the flag drops, the host reads back the bits that were sampled during the run. Entry 0 serves as the idle anchor. It has busy cleared, and the last entry of every chain links back to it. Each busy entry holds the lines for a fixed number of clock cycles set by a prescaler parameter, which sets the bus rate.

Top module: `i2c_useq`

## Requirements
- R1: While in reset and right after it, scl_o and sda_o are 1 (released), running_o is 0 and rd_data_o is 0.
- R2: A write word stored with wr_en_i carries the entry address at bits [18 +: ADDR_W], busy at bit 13, sample-enable at bit 12, SCL-low at bit 11, SDA-low at bit 10 and the next-entry address at bits [ADDR_W-1:0]. Other bits are ignored.
- R3: When an entry has its SCL-low bit set, scl_o is 0 while that entry runs, and 1 otherwise. The SDA-low bit drives sda_o in the same way.
- R4: The levels of each busy entry appear on the lines for exactly PRESCALE cycles. The entry named by that entry's next field then follows.
- R5: A kick while idle starts execution at entry 1. running_o is 1 in the cycle after the kick, and the levels of entry 1 appear one cycle later.
- R6: When execution reaches an entry with busy clear, that entry's levels are applied and running_o falls in the same cycle. A chain of N busy entries therefore keeps running_o high for N*PRESCALE+1 cycles.
- R7: A busy entry with sample-enable set samples sda_i in the last cycle of its hold. The sampled bit is shifted into bit 0 of rd_data_o, and older bits move toward the MSB.
- R8: A kick that arrives while running_o is 1 is ignored. The run is not restarted, its length does not change and rd_data_o is not cleared.
- R9: A kick that is accepted clears rd_data_o to 0.
- R10: While idle, scl_o, sda_o and rd_data_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Store wr_data_i as one entry |
| wr_data_i | input | 32 | Entry write word (see R2) |
| kick_i | input | 1 | Start execution at entry 1 |
| sda_i | input | 1 | Sensed SDA level |
| scl_o | output | 1 | SCL level, 1 = released |
| sda_o | output | 1 | SDA level, 1 = released |
| running_o | output | 1 | Program is executing |
| rd_data_o | output | DATA_W | Sampled-bit shift register |

## Verification
The bench builds the block with ADDR_W=6, PRESCALE=3 and DATA_W=8. The small store lets the bench rewrite every entry before each run and send chains to idle entries other than 0. The short hold keeps each run to a few dozen cycles, so hundreds of random programs fit in the run. An 8-bit shift register is filled and then overflows within a single read chain. The random programs also place kicks in the middle of runs, which checks that a second kick cannot restart or clear an active run.

// File: rtl/i2c_useq_pkg.sv
package i2c_useq_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_LSB  = 18;
  localparam int BUSY_BIT  = 13;
  localparam int RDEN_BIT  = 12;
  localparam int SCLN_BIT  = 11;
  localparam int SDAN_BIT  = 10;
  localparam int MAX_ADDR_W = 10;

  typedef struct packed {
    logic busy;
    logic rd_en;
    logic scl_n;
    logic sda_n;
  } useq_ctl_t;

  function automatic useq_ctl_t ctl_of(input logic [WORD_W-1:0] w);
    useq_ctl_t c;
    c.busy  = w[BUSY_BIT];
    c.rd_en = w[RDEN_BIT];
    c.scl_n = w[SCLN_BIT];
    c.sda_n = w[SDAN_BIT];
    return c;
  endfunction
endpackage

// File: rtl/i2c_useq_store.sv
module i2c_useq_store
  import i2c_useq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  useq_ctl_t         wr_ctl_i,
  input  logic [ADDR_W-1:0] wr_next_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output useq_ctl_t         rd_ctl_o,
  output logic [ADDR_W-1:0] rd_next_o
);
  localparam int DEPTH = 1 << ADDR_W;

  useq_ctl_t         ctl_mem  [DEPTH];
  logic [ADDR_W-1:0] next_mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      ctl_mem[wr_addr_i]  <= wr_ctl_i;
      next_mem[wr_addr_i] <= wr_next_i;
    end
  end

  assign rd_ctl_o  = ctl_mem[rd_addr_i];
  assign rd_next_o = next_mem[rd_addr_i];
endmodule

// File: rtl/i2c_useq_engine.sv
module i2c_useq_engine
  import i2c_useq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PRESCALE = 250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kick_i,
  input  useq_ctl_t         ctl_i,
  input  logic [ADDR_W-1:0] next_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              running_o,
  output logic              entry_start_o,
  output logic              sample_o,
  output logic              clear_o,
  output logic              scl_o,
  output logic              sda_o
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(PRESCALE - 1);
  localparam logic [ADDR_W-1:0] START_PC = ADDR_W'(1);

  logic              run_q;
  logic [ADDR_W-1:0] pc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              scl_q, sda_q;
  logic              at_start, at_last, halt;

  assign at_start = run_q && (cnt_q == '0);
  assign at_last  = cnt_q == CNT_LAST;
  assign halt     = at_start && !ctl_i.busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pc_q  <= '0;
      cnt_q <= '0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else if (!run_q) begin
      if (kick_i) begin
        run_q <= 1'b1;
        pc_q  <= START_PC;
        cnt_q <= '0;
      end
    end else if (halt) begin
      // idle entry: apply its levels and stop
      scl_q <= !ctl_i.scl_n;
      sda_q <= !ctl_i.sda_n;
      run_q <= 1'b0;
    end else begin
      if (cnt_q == '0) begin
        scl_q <= !ctl_i.scl_n;
        sda_q <= !ctl_i.sda_n;
      end
      if (at_last) begin
        pc_q  <= next_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pc_o          = pc_q;
  assign running_o     = run_q;
  assign entry_start_o = at_start;
  assign sample_o      = run_q && ctl_i.busy && ctl_i.rd_en && at_last;
  assign clear_o       = !run_q && kick_i;
  assign scl_o         = scl_q;
  assign sda_o         = sda_q;
endmodule

// File: rtl/i2c_useq_shift.sv
module i2c_useq_shift #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] sh_q;

  generate
    if (DATA_W == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sh_q <= '0;
        else if (clear_i) sh_q <= '0;
        else if (shift_i) sh_q <= bit_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sh_q <= '0;
        else if (clear_i) sh_q <= '0;
        else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], bit_i};
      end
    end
  endgenerate

  assign data_o = sh_q;
endmodule

// File: rtl/i2c_useq.sv
module i2c_useq
  import i2c_useq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PRESCALE = 250,
  parameter int DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              kick_i,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              running_o,
  output logic [DATA_W-1:0] rd_data_o
);
  useq_ctl_t         wr_ctl, cur_ctl;
  logic [ADDR_W-1:0] wr_addr, wr_next, cur_next, pc;
  logic              at_start, cur_busy, sample, clear;
  logic              unused_wr;

  assign wr_ctl    = ctl_of(wr_data_i);
  assign wr_addr   = wr_data_i[ADDR_LSB +: ADDR_W];
  assign wr_next   = wr_data_i[ADDR_W-1:0];
  assign unused_wr = ^wr_data_i;
  assign cur_busy  = cur_ctl.busy;

  i2c_useq_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr),
    .wr_ctl_i  (wr_ctl),
    .wr_next_i (wr_next),
    .rd_addr_i (pc),
    .rd_ctl_o  (cur_ctl),
    .rd_next_o (cur_next)
  );

  i2c_useq_engine #(.ADDR_W(ADDR_W), .PRESCALE(PRESCALE)) u_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .kick_i        (kick_i),
    .ctl_i         (cur_ctl),
    .next_i        (cur_next),
    .pc_o          (pc),
    .running_o     (running_o),
    .entry_start_o (at_start),
    .sample_o      (sample),
    .clear_o       (clear),
    .scl_o         (scl_o),
    .sda_o         (sda_o)
  );

  i2c_useq_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .shift_i (sample),
    .bit_i   (sda_i),
    .data_o  (rd_data_o)
  );
endmodule

// File: rtl/i2c_useq_chk.sv
module i2c_useq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              kick_i,
  input logic              running_o,
  input logic              scl_o,
  input logic              sda_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              at_start_i,
  input logic              cur_busy_i
);
  a_r9_kick_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && kick_i) |=> (running_o && rd_data_o == '0));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !kick_i) |=>
      (!running_o && $stable(scl_o) && $stable(sda_o) && $stable(rd_data_o)));

  a_r4_hold_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !at_start_i) |=> ($stable(scl_o) && $stable(sda_o)));

  a_r6_stop_on_idle_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_start_i && !cur_busy_i) |=> !running_o);

  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && kick_i && !(at_start_i && !cur_busy_i)) |=> running_o);
endmodule

bind i2c_useq i2c_useq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .kick_i     (kick_i),
  .running_o  (running_o),
  .scl_o      (scl_o),
  .sda_o      (sda_o),
  .rd_data_o  (rd_data_o),
  .at_start_i (at_start),
  .cur_busy_i (cur_busy)
);

// File: tb/i2c_useq_test.sv
module i2c_useq_test;
  localparam int AW = 6;
  localparam int P  = 3;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, kick = 1'b0, sda_in = 1'b1;
  logic [31:0] wr_data = '0;
  logic scl_o, sda_o, running_o;
  logic [DW-1:0] rd_data_o;

  int checks = 0, errors = 0, cyc = 0;
  bit cmp_on = 1'b0, rand_sda = 1'b0, rand_kick = 1'b0;

  // reference state, built from the requirements
  int m_busy[N], m_rd[N], m_scln[N], m_sdan[N], m_next[N];
  int m_run, m_pc, m_cnt, m_scl, m_sda, m_sh;

  always #2 clk = ~clk;

  i2c_useq #(.ADDR_W(AW), .PRESCALE(P), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .kick_i(kick), .sda_i(sda_in), .scl_o(scl_o), .sda_o(sda_o),
    .running_o(running_o), .rd_data_o(rd_data_o));

  function automatic logic [31:0] enc(int a, int b, int r, int c, int d, int nx);
    return (32'(a) << 18) | (32'(b) << 13) | (32'(r) << 12) |
           (32'(c) << 11) | (32'(d) << 10) | 32'(nx);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_pc = 0; m_cnt = 0; m_scl = 1; m_sda = 1; m_sh = 0;
    end else begin
      if (m_run == 0) begin
        if (kick) begin m_run = 1; m_pc = 1; m_cnt = 0; m_sh = 0; end
      end else if (m_cnt == 0 && m_busy[m_pc] == 0) begin
        m_scl = 1 - m_scln[m_pc]; m_sda = 1 - m_sdan[m_pc]; m_run = 0;
      end else begin
        if (m_cnt == 0) begin m_scl = 1 - m_scln[m_pc]; m_sda = 1 - m_sdan[m_pc]; end
        if (m_cnt == P - 1) begin
          if (m_rd[m_pc] != 0) m_sh = ((m_sh << 1) | int'(sda_in)) & ((1 << DW) - 1);
          m_pc = m_next[m_pc]; m_cnt = 0;
        end else m_cnt++;
      end
      if (wr_en) begin
        int a;
        a = int'(wr_data[18 +: AW]);
        m_busy[a] = int'(wr_data[13]); m_rd[a] = int'(wr_data[12]);
        m_scln[a] = int'(wr_data[11]); m_sdan[a] = int'(wr_data[10]);
        m_next[a] = int'(wr_data[AW-1:0]);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R3/R4 scl", int'(scl_o), m_scl);
      chk("R3/R4 sda", int'(sda_o), m_sda);
      chk("R5/R6/R8 running", int'(running_o), m_run);
      chk("R7/R9 rd_data", int'(rd_data_o), m_sh);
    end
    if (rand_sda) sda_in <= 1'($urandom_range(0, 1));
    if (rand_kick) kick <= ($urandom_range(0, 7) == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, int b, int r, int c, int d, int nx);
    @(negedge clk); wr_en = 1'b1; wr_data = enc(a, b, r, c, d, nx);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    chk("R5 running after kick", int'(running_o), 1);
  endtask

  task automatic run_len(output int n);
    n = 0;
    while (running_o && n < 5000) begin n++; @(negedge clk); end
  endtask

  int len;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 scl reset", int'(scl_o), 1);
    chk("R1 sda reset", int'(sda_o), 1);
    chk("R1 running reset", int'(running_o), 0);
    chk("R1 rd_data reset", int'(rd_data_o), 0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) wr(i, 0, 0, 0, 0, 0);
    cmp_on = 1'b1;

    // R2/R6: start, one written zero bit, stop; 9 busy entries
    wr(1, 1, 0, 0, 0, 2); wr(2, 1, 0, 0, 1, 3); wr(3, 1, 0, 1, 1, 4);
    wr(4, 1, 0, 1, 1, 5); wr(5, 1, 0, 0, 1, 6); wr(6, 1, 0, 1, 1, 7);
    wr(7, 1, 0, 1, 1, 8); wr(8, 1, 0, 0, 1, 9); wr(9, 1, 0, 0, 0, 0);
    // unused bits in the write word are set high: must not alter entry 0 (R2)
    @(negedge clk); wr_en = 1'b1; wr_data = enc(0, 0, 0, 0, 0, 0) | 32'hF003_C000;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    do_kick();
    run_len(len);
    chk("R6 run length 9 entries", len, 9 * P + 1);
    chk("R6 idle scl", int'(scl_o), 1);
    chk("R6 idle sda", int'(sda_o), 1);
    repeat (5) @(negedge clk);
    chk("R10 idle scl held", int'(scl_o), 1);

    // R7: 12 read bits with sda high; 8-bit register saturates to all ones
    for (int b = 0; b < 12; b++) begin
      wr(1 + 4*b, 1, 0, 1, 0, 2 + 4*b);
      wr(2 + 4*b, 1, 0, 0, 0, 3 + 4*b);
      wr(3 + 4*b, 1, 1, 0, 0, 4 + 4*b);
      wr(4 + 4*b, 1, 0, 1, 0, (b == 11) ? 0 : 5 + 4*b);
    end
    sda_in = 1'b1;
    do_kick();
    run_len(len);
    chk("R7 run length 48 entries", len, 48 * P + 1);
    chk("R7 read ones", int'(rd_data_o), 8'hFF);

    // R8: kick in the middle of the run neither restarts nor clears
    sda_in = 1'b0;
    do_kick();
    repeat (20) @(negedge clk);
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    run_len(len);
    chk("R8 run length unchanged", len, 48 * P + 1 - 21);
    chk("R8 zeros shifted", int'(rd_data_o), 0);

    // R9: ones, then a chain with no read entries clears the register
    sda_in = 1'b1;
    do_kick(); run_len(len);
    wr(1, 1, 0, 1, 1, 0);
    do_kick();
    chk("R9 cleared on kick", int'(rd_data_o), 0);
    run_len(len);
    chk("R9 still clear", int'(rd_data_o), 0);

    // random chains, random sda and random kicks
    rand_sda = 1'b1;
    for (int it = 0; it < 300; it++) begin
      int l, term;
      l = $urandom_range(1, 20);
      term = ($urandom_range(0, 1) == 0) ? 0 : l + 1;
      rand_kick = 1'b0; kick = 1'b0;
      for (int e = 1; e <= l; e++)
        wr(e, 1, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           (e == l) ? term : e + 1);
      if (term != 0) wr(term, 0, 0, $urandom_range(0, 1), $urandom_range(0, 1), 0);
      wr(0, 0, 0, 0, 0, 0);
      rand_kick = 1'b1;
      while (!running_o) @(negedge clk);
      run_len(len);
      rand_kick = 1'b0; kick = 1'b0;
      @(negedge clk);
      while (running_o) @(negedge clk);
    end
    rand_sda = 1'b0;
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial $urandom(32'd12345);
endmodule